// File: doc/BRIEF.md
# Serial 1101 Pattern Detector

This block watches a one-bit serial stream, sampled on each rising clock edge, and flags each completion of the bit sequence 1,1,0,1. Matches may overlap: the final 1 of one match can serve as the first 1 of the next. The flag is a Mealy output. It is formed combinationally from the present state and the current input bit, so it is valid in the same cycle in which that bit is sampled.

The machine has four states, named A to D in this document. A compile-time parameter selects how these states are stored in flip-flops: counting-order binary, reflected Gray code, or one-hot. The state register is exposed on a port, so integrators and benches can see the encoding that was chosen. Every encoding gives the same flag behaviour at the ports. The active-low asynchronous reset returns the machine to state A.

Top module: `pattern_watch_fsm`

## Requirements
- R1: While `rst_ni` is low, the state is A and `state_o` shows the A code of the selected encoding, at once and without waiting for a clock edge.
- R2: From state A, the next state is B if `x_i`=1 and stays A if `x_i`=0.
- R3: From state B, the next state is C if `x_i`=1 and A if `x_i`=0.
- R4: From state C, the next state stays C if `x_i`=1 and is D if `x_i`=0.
- R5: From state D, the next state is B if `x_i`=1 (overlap) and A if `x_i`=0.
- R6: `z_o` is 1 exactly when the present state is D and `x_i`=1. It follows `x_i` within the same cycle, with no register in between.
- R7: Binary encoding (`ENC`=ENC_BIN) gives a 2-bit `state_o` with A=00, B=01, C=10, D=11.
- R8: Gray encoding (`ENC`=ENC_GRAY) gives a 2-bit `state_o` with A=00, B=01, C=11, D=10.
- R9: One-hot encoding (`ENC`=ENC_ONEHOT) gives a 4-bit `state_o` with A=0001, B=0010, C=0100, D=1000. Any stored value that does not have exactly one bit set is replaced by A at the next edge.
- R10: For the same reset and input sequence, all three encodings give identical `z_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Serial data bit |
| z_o | output | 1 | Pattern-complete flag (Mealy) |
| state_o | output | STATE_W (2, or 4 for one-hot) | Encoded present state |

## Verification
The hardest case to reach is the overlap path. The stream must go through A, B, C and D and then present a 1. That 1 must raise the flag in the same cycle and also steer the machine to B rather than to A, so that a second match can finish only three bits later. The stimulus sends 1,1,0,1,1,0,1 and expects two flags. It also sends extra 1s in state C to exercise the C self-loop. All three encodings are instantiated side by side and driven by the same bit stream, so any difference in the flag or in a state code is reported against its own encoding.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
package pd_pkg;
  typedef enum logic [1:0] {ENC_BIN = 2'd0, ENC_GRAY = 2'd1, ENC_ONEHOT = 2'd2} enc_e;
  typedef enum logic [1:0] {ST_A = 2'd0, ST_B = 2'd1, ST_C = 2'd2, ST_D = 2'd3} sym_e;

  function automatic int unsigned state_width(enc_e e);
    return (e == ENC_ONEHOT) ? 4 : 2;
  endfunction

  function automatic logic [3:0] encode(enc_e e, sym_e s);
    logic [3:0] r;
    case (e)
      ENC_GRAY:   r = {2'b00, s[1], s[1] ^ s[0]};
      ENC_ONEHOT: r = 4'b0001 << s;
      default:    r = {2'b00, s};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pd_transition.sv
`timescale 1ns/1ps
module pd_transition
  import pd_pkg::*;
(
  input  sym_e cur_i,
  input  logic legal_i,
  input  logic x_i,
  output sym_e nxt_o,
  output logic z_o
);
  always_comb begin
    nxt_o = ST_A;
    z_o   = 1'b0;
    if (legal_i) begin
      case (cur_i)
        ST_A: nxt_o = x_i ? ST_B : ST_A;
        ST_B: nxt_o = x_i ? ST_C : ST_A;
        ST_C: nxt_o = x_i ? ST_C : ST_D;
        ST_D: begin
          nxt_o = x_i ? ST_B : ST_A;
          z_o   = x_i;
        end
        default: nxt_o = ST_A;
      endcase
    end
  end
endmodule

// File: rtl/pd_state_store.sv
`timescale 1ns/1ps
module pd_state_store
  import pd_pkg::*;
#(
  parameter enc_e ENC = ENC_BIN,
  parameter int unsigned W = state_width(ENC)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  sym_e         nxt_i,
  output sym_e         cur_o,
  output logic         legal_o,
  output logic [W-1:0] state_o
);
  if (ENC == ENC_ONEHOT) begin : g_oh
    logic [3:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 4'b0001;
      else         q <= 4'b0001 << nxt_i;
    end
    // decode tests a single bit per state; illegal values are flagged
    assign legal_o = ($countones(q) == 1);
    always_comb begin
      if (q[1])      cur_o = ST_B;
      else if (q[2]) cur_o = ST_C;
      else if (q[3]) cur_o = ST_D;
      else           cur_o = ST_A;
    end
    assign state_o = q;
  end else if (ENC == ENC_GRAY) begin : g_gray
    logic [1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 2'b00;
      else         q <= {nxt_i[1], nxt_i[1] ^ nxt_i[0]};
    end
    assign legal_o = 1'b1;
    assign cur_o   = sym_e'({q[1], q[1] ^ q[0]});
    assign state_o = q;
  end else begin : g_bin
    logic [1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 2'b00;
      else         q <= nxt_i;
    end
    assign legal_o = 1'b1;
    assign cur_o   = sym_e'(q);
    assign state_o = q;
  end
endmodule

// File: rtl/pattern_watch_fsm.sv
`timescale 1ns/1ps
module pattern_watch_fsm
  import pd_pkg::*;
#(
  parameter enc_e ENC = ENC_BIN,
  localparam int unsigned STATE_W = state_width(ENC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               x_i,
  output logic               z_o,
  output logic [STATE_W-1:0] state_o
);
  sym_e cur_sym, nxt_sym;
  logic legal;

  pd_state_store #(.ENC(ENC), .W(STATE_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nxt_i   (nxt_sym),
    .cur_o   (cur_sym),
    .legal_o (legal),
    .state_o (state_o)
  );

  pd_transition u_trans (
    .cur_i   (cur_sym),
    .legal_i (legal),
    .x_i     (x_i),
    .nxt_o   (nxt_sym),
    .z_o     (z_o)
  );
endmodule

// File: rtl/pd_checker.sv
`timescale 1ns/1ps
module pd_checker
  import pd_pkg::*;
#(
  parameter enc_e ENC = ENC_BIN,
  localparam int unsigned W = state_width(ENC)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         x_i,
  input logic         z_o,
  input logic [W-1:0] state_o
);
  localparam logic [3:0] FA = encode(ENC, ST_A);
  localparam logic [3:0] FB = encode(ENC, ST_B);
  localparam logic [3:0] FC = encode(ENC, ST_C);
  localparam logic [3:0] FD = encode(ENC, ST_D);
  localparam logic [W-1:0] CA = FA[W-1:0];
  localparam logic [W-1:0] CB = FB[W-1:0];
  localparam logic [W-1:0] CC = FC[W-1:0];
  localparam logic [W-1:0] CD = FD[W-1:0];

  assert_reset_state_R1: assert property (@(posedge clk_i) !rst_ni |-> state_o == CA);

  assert_a_stay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CA && !x_i) |=> state_o == CA);
  assert_a_go_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CA && x_i) |=> state_o == CB);
  assert_b_back_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CB && !x_i) |=> state_o == CA);
  assert_b_go_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CB && x_i) |=> state_o == CC);
  assert_c_stay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CC && x_i) |=> state_o == CC);
  assert_c_go_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CC && !x_i) |=> state_o == CD);
  assert_d_back_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CD && !x_i) |=> state_o == CA);
  assert_d_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == CD && x_i) |=> state_o == CB);
  assert_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_o == (state_o == CD && x_i));

  if (ENC == ENC_ONEHOT) begin : g_oh_chk
    assert_one_hot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(state_o) == 1);
  end
endmodule

bind pattern_watch_fsm pd_checker #(.ENC(ENC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .x_i     (x_i),
  .z_o     (z_o),
  .state_o (state_o)
);

// File: tb/pattern_watch_fsm_tb_top.sv
`timescale 1ns/1ps
module pattern_watch_fsm_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic x = 1'b0;
  logic z_bin, z_gray, z_oh;
  logic [1:0] st_bin, st_gray;
  logic [3:0] st_oh;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pattern_watch_fsm #(.ENC(pd_pkg::ENC_BIN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .z_o(z_bin), .state_o(st_bin));
  pattern_watch_fsm #(.ENC(pd_pkg::ENC_GRAY)) dut_gray_i (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .z_o(z_gray), .state_o(st_gray));
  pattern_watch_fsm #(.ENC(pd_pkg::ENC_ONEHOT)) dut_oh_i (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .z_o(z_oh), .state_o(st_oh));

  localparam int A = 0, B = 1, C = 2, D = 3;

  function automatic logic [1:0] bin_code(int s);
    case (s) 0: return 2'b00; 1: return 2'b01; 2: return 2'b10; default: return 2'b11; endcase
  endfunction
  function automatic logic [1:0] gray_code(int s);
    case (s) 0: return 2'b00; 1: return 2'b01; 2: return 2'b11; default: return 2'b10; endcase
  endfunction
  function automatic logic [3:0] oh_code(int s);
    case (s) 0: return 4'b0001; 1: return 4'b0010; 2: return 4'b0100; default: return 4'b1000; endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic chk_state(input int es, input string rq);
    chk(st_bin == bin_code(es), $sformatf("%s R7 bin state", rq), st_bin, bin_code(es));
    chk(st_gray == gray_code(es), $sformatf("%s R8 gray state", rq), st_gray, gray_code(es));
    chk(st_oh == oh_code(es), $sformatf("%s R9 onehot state", rq), st_oh, oh_code(es));
  endtask

  // drive x at negedge, check z before the edge, check next state after it
  task automatic apply(input logic xv, input logic ez, input int es, input string rq);
    @(negedge clk);
    x = xv;
    #1;
    chk(z_bin == ez, "R6 z bin", z_bin, ez);
    chk(z_gray == ez, "R10 z gray", z_gray, ez);
    chk(z_oh == ez, "R10 z onehot", z_oh, ez);
    @(posedge clk);
    #1;
    chk_state(es, rq);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk_state(A, "R1");
    chk(z_bin == 1'b0, "R1 z", z_bin, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    x = 1'b0;
    do_reset();
    apply(1'b0, 1'b0, A, "R2");
  endtask

  task automatic t_state_a();
    apply(1'b0, 1'b0, A, "R2");
    apply(1'b1, 1'b0, B, "R2");
  endtask

  task automatic t_state_b();
    apply(1'b0, 1'b0, A, "R3");
    apply(1'b1, 1'b0, B, "R2");
    apply(1'b1, 1'b0, C, "R3");
  endtask

  task automatic t_state_c();
    apply(1'b1, 1'b0, C, "R4");
    apply(1'b1, 1'b0, C, "R4");
    apply(1'b0, 1'b0, D, "R4");
  endtask

  task automatic t_state_d_back();
    apply(1'b0, 1'b0, A, "R5");
  endtask

  // 1101101: two overlapping matches
  task automatic t_overlap();
    apply(1'b1, 1'b0, B, "R2");
    apply(1'b1, 1'b0, C, "R3");
    apply(1'b0, 1'b0, D, "R4");
    apply(1'b1, 1'b1, B, "R5");
    apply(1'b1, 1'b0, C, "R3");
    apply(1'b0, 1'b0, D, "R4");
    apply(1'b1, 1'b1, B, "R5");
    apply(1'b0, 1'b0, A, "R3");
  endtask

  task automatic t_mid_reset();
    apply(1'b1, 1'b0, B, "R2");
    apply(1'b1, 1'b0, C, "R3");
    apply(1'b0, 1'b0, D, "R4");
    @(negedge clk);
    x = 1'b1;
    #0.5;
    chk(z_bin == 1'b1, "R6 z in D", z_bin, 1);
    rst_n = 1'b0;
    #0.5;
    chk_state(A, "R1 async");
    chk(z_oh == 1'b0, "R1 z after reset", z_oh, 0);
    @(negedge clk);
    x = 1'b0;
    rst_n = 1'b1;
    apply(1'b0, 1'b0, A, "R2");
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #3 rst_n = 1'b1;
    t_reset();
    t_state_a();
    t_state_b();
    t_state_c();
    t_state_d_back();
    t_overlap();
    t_mid_reset();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule